// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked requester and an external asynchronous static RAM with a 16-bit data word. The requester presents one access at a time: an address, a read/write flag, one enable per byte lane and the write word. It holds `req` high until it sees a single-cycle `ack`. The sequencer then drives the memory's select, write-strobe, output-enable and lane-enable pins in the correct order. It counts clock cycles so that every minimum cycle time, pulse width, setup time and bus release delay is met.

Each timing figure is a parameter in nanoseconds. It is turned into a cycle count by rounding up against the clock-period parameter, and every count is at least one cycle. The sequencer owns the enable of the data-bus output buffer. It keeps the memory deselected until the supply settling time after reset has passed. Read words are registered, and the ack pulse marks when they are valid.

Top module: `asram_seq_ctrl`

## Requirements
- R1: After reset, all memory pins are inactive: `sram_sel_n`=1, `sram_sel`=0, `sram_we_n`=1, `sram_oe_n`=1, `sram_lane_n`=2'b11, `sram_dq_oe`=0 and `ack`=0. The memory stays deselected for at least ceil(T_PWRUP_NS/CLK_NS) cycles after reset, and a request made earlier waits.
- R2: A read asserts both selects, drives `sram_oe_n` low and keeps `sram_we_n` high. It drives `sram_lane_n[i]` = ~`req_be[i]`, with lane 0 being bits 7:0 and lane 1 being bits 15:8. It holds this for ceil(max(tRC,tAA,tDOE)/clk) cycles and registers `sram_dq_in` on the last of those cycles.
- R3: In the returned `rdata`, a byte lane whose enable was 0 reads as 8'h00.
- R4: During a write, `sram_oe_n` stays high. `sram_we_n` is low for at least the pulse count, and `sram_dq_oe` is 1 with `sram_dq_out` unchanged for every cycle that `sram_we_n` is low.
- R5: The sequencer turns on `sram_dq_oe` only after `sram_oe_n` has been high for at least ceil(tHZ/clk) cycles, so it never drives while the memory may still drive.
- R6: `sram_dq_oe` stays 1 in the cycle in which `sram_we_n` returns high, and is 0 in the cycle after that.
- R7: `sram_addr` does not change while the memory is selected. The memory is deselected for at least one cycle between two accesses.
- R8: Every accepted request produces exactly one `ack` pulse, one cycle long. A new request is accepted only after the previous `ack`.
- R9: A request with `req_be`=2'b00 is acknowledged without any memory pin changing, `sram_addr` included.
- R10: A write changes only the byte lanes whose enable is 1. The other lane keeps its old contents.
- R11: Each access keeps the memory selected for at least ceil(max(tRC,tWC)/clk) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Access request, held until ack |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_be | input | DW/8 | Byte-lane enables, bit 0 = low byte |
| req_wdata | input | DW | Write word |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Read word, valid with ack |
| sram_addr | output | AW | Memory address pins |
| sram_sel_n | output | 1 | Active-low chip select |
| sram_sel | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_lane_n | output | DW/8 | Active-low byte-lane enables |
| sram_dq_out | output | DW | Data driven towards the memory |
| sram_dq_in | input | DW | Data received from the memory |
| sram_dq_oe | output | 1 | Enable of the data-bus output buffer |

## Verification
The bench uses a memory model that returns a marker word until a read has lasted the full access count. It keeps driving the bus for two cycles after its output enable is withdrawn, and it commits a write only at the edge where the write strobe ends. Full-word writes and reads establish the basic path. Single-lane writes followed by full reads separate correct lane masking from whole-word updates. Single-lane reads show whether the disabled lane is zeroed. A read followed directly by a write exposes a turn-around that is too short. A request with no lanes enabled shows whether the pins stay quiet. A sweep over several addresses with varying data catches address and data mix-ups.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_PWR,
      ST_IDLE,
      ST_RD,
      ST_WTA,
      ST_WPL,
      ST_WHD
   } seq_state_t;

   // Round a time in ns up to whole clock cycles, never below one cycle.
   function automatic int ns2cyc(input int t_ns, input int clk_ns);
      int c;
      c = (t_ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_phase_tmr.sv
// Loadable down-counter: a phase loaded with N-1 lasts N cycles.
module asram_phase_tmr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (load)           cnt <= load_val;
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/asram_pwrup.sv
// Counts the supply settling time after reset.
module asram_pwrup #(
   parameter int CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic ok
);
   localparam int W = $clog2(CYC + 1);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (!ok) cnt <= cnt + 1'b1;
   end

   assign ok = (cnt == W'(CYC));
endmodule

// File: rtl/asram_seq_ctrl.sv
module asram_seq_ctrl
   import asram_pkg::*;
#(
   parameter int AW          = 20,
   parameter int DW          = 16,
   parameter int CLK_NS      = 8,
   parameter int T_PWRUP_NS  = 200000,
   parameter int T_RC_NS     = 55,
   parameter int T_AA_NS     = 55,
   parameter int T_DOE_NS    = 25,
   parameter int T_WC_NS     = 55,
   parameter int T_PWE_NS    = 40,
   parameter int T_SD_NS     = 25,
   parameter int T_HZ_NS     = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req,
   input  logic                 req_wr,
   input  logic [AW-1:0]        req_addr,
   input  logic [DW/8-1:0]      req_be,
   input  logic [DW-1:0]        req_wdata,
   output logic                 ack,
   output logic [DW-1:0]        rdata,
   output logic [AW-1:0]        sram_addr,
   output logic                 sram_sel_n,
   output logic                 sram_sel,
   output logic                 sram_we_n,
   output logic                 sram_oe_n,
   output logic [DW/8-1:0]      sram_lane_n,
   output logic [DW-1:0]        sram_dq_out,
   input  logic [DW-1:0]        sram_dq_in,
   output logic                 sram_dq_oe
);
   localparam int LANES   = DW / 8;
   localparam int PWR_CYC = ns2cyc(T_PWRUP_NS, CLK_NS);
   localparam int RD_CYC  = imax(ns2cyc(T_RC_NS, CLK_NS),
                                 imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_DOE_NS, CLK_NS)));
   localparam int HZ_CYC  = ns2cyc(T_HZ_NS, CLK_NS);
   // Strobe must cover pulse width, data setup and the rest of the write cycle.
   localparam int WPL_CYC = imax(imax(ns2cyc(T_PWE_NS, CLK_NS), ns2cyc(T_SD_NS, CLK_NS)),
                                 ns2cyc(T_WC_NS, CLK_NS) - HZ_CYC - 1);
   localparam int TW      = $clog2(imax(RD_CYC, imax(HZ_CYC, WPL_CYC)) + 1);
   localparam logic [TW-1:0] RD_LD  = TW'(RD_CYC - 1);
   localparam logic [TW-1:0] HZ_LD  = TW'(HZ_CYC - 1);
   localparam logic [TW-1:0] WPL_LD = TW'(WPL_CYC - 1);

   if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
      $error("asram_seq_ctrl: DW must be a positive multiple of 8");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("asram_seq_ctrl: CLK_NS must be at least 1");
   end
   if (AW < 1) begin : g_bad_aw
      $error("asram_seq_ctrl: AW must be at least 1");
   end

   seq_state_t         state, state_d;
   logic               pwr_ok;
   logic               tmr_load, tmr_exp;
   logic [TW-1:0]      tmr_val;
   logic               accept;
   logic [AW-1:0]      addr_q;
   logic [LANES-1:0]   be_q;
   logic [DW-1:0]      wdata_q;
   logic [DW-1:0]      rdata_q;
   logic [DW-1:0]      rd_masked;
   logic               ack_q;

   asram_pwrup #(.CYC(PWR_CYC)) u_pwr (
      .clk   (clk),
      .rst_n (rst_n),
      .ok    (pwr_ok)
   );

   asram_phase_tmr #(.W(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   assign accept = (state == ST_IDLE) && req && !ack_q;

   always_comb begin
      state_d  = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state)
         ST_PWR:  if (pwr_ok) state_d = ST_IDLE;
         ST_IDLE: if (accept && req_be != '0) begin
            tmr_load = 1'b1;
            if (req_wr) begin
               state_d = ST_WTA;
               tmr_val = HZ_LD;
            end else begin
               state_d = ST_RD;
               tmr_val = RD_LD;
            end
         end
         ST_RD:   if (tmr_exp) state_d = ST_IDLE;
         ST_WTA:  if (tmr_exp) begin
            state_d  = ST_WPL;
            tmr_load = 1'b1;
            tmr_val  = WPL_LD;
         end
         ST_WPL:  if (tmr_exp) state_d = ST_WHD;
         ST_WHD:  state_d = ST_IDLE;
         default: state_d = ST_PWR;
      endcase
   end

   // Lanes that were not requested read back as zero.
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign rd_masked[g*8 +: 8] = be_q[g] ? sram_dq_in[g*8 +: 8] : 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_PWR;
         addr_q  <= '0;
         be_q    <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         ack_q   <= 1'b0;
      end else begin
         state <= state_d;
         ack_q <= (accept && req_be == '0) || (state == ST_RD && tmr_exp) ||
                  (state == ST_WHD);
         if (accept && req_be != '0) begin
            addr_q  <= req_addr;
            be_q    <= req_be;
            wdata_q <= req_wdata;
         end
         if (state == ST_RD && tmr_exp) rdata_q <= rd_masked;
      end
   end

   logic sel_act;
   assign sel_act     = (state == ST_RD) || (state == ST_WTA) ||
                        (state == ST_WPL) || (state == ST_WHD);
   assign sram_sel_n  = !sel_act;
   assign sram_sel    = sel_act;
   assign sram_oe_n   = (state != ST_RD);
   assign sram_we_n   = (state != ST_WPL);
   assign sram_lane_n = (state == ST_RD || state == ST_WPL) ? ~be_q : '1;
   assign sram_dq_oe  = (state == ST_WPL) || (state == ST_WHD);
   assign sram_addr   = addr_q;
   assign sram_dq_out = wdata_q;
   assign ack         = ack_q;
   assign rdata       = rdata_q;
endmodule

// File: rtl/asram_seq_chk.sv
module asram_seq_chk #(
   parameter int AW      = 20,
   parameter int DW      = 16,
   parameter int HZ_CYC  = 3,
   parameter int WPL_CYC = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pwr_ok,
   input logic          sram_sel_n,
   input logic          sram_sel,
   input logic          sram_we_n,
   input logic          sram_oe_n,
   input logic          sram_dq_oe,
   input logic [DW-1:0] sram_dq_out,
   input logic [AW-1:0] sram_addr,
   input logic          ack
);
   logic [7:0] we_lo_cnt;
   logic [7:0] oe_hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_lo_cnt <= '0;
         oe_hi_cnt <= '0;
      end else begin
         we_lo_cnt <= !sram_we_n ? ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 1'b1) : '0;
         oe_hi_cnt <= sram_oe_n  ? ((oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 1'b1) : '0;
      end
   end

   // R1
   pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ok |-> (sram_sel_n && !sram_sel));

   // R4
   oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (sram_oe_n && sram_dq_oe));

   // R4
   we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (we_lo_cnt >= 8'(WPL_CYC)));

   // R4
   wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_we_n && !$past(sram_we_n)) |-> $stable(sram_dq_out));

   // R5
   turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_dq_oe) |-> (oe_hi_cnt >= 8'(HZ_CYC)));

   // R6
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (sram_dq_oe ##1 !sram_dq_oe));

   // R7
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_sel_n && !$past(sram_sel_n)) |-> $stable(sram_addr));

   // R8
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);
endmodule

bind asram_seq_ctrl asram_seq_chk #(
   .AW(AW), .DW(DW), .HZ_CYC(HZ_CYC), .WPL_CYC(WPL_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwr_ok      (pwr_ok),
   .sram_sel_n  (sram_sel_n),
   .sram_sel    (sram_sel),
   .sram_we_n   (sram_we_n),
   .sram_oe_n   (sram_oe_n),
   .sram_dq_oe  (sram_dq_oe),
   .sram_dq_out (sram_dq_out),
   .sram_addr   (sram_addr),
   .ack         (ack)
);

// File: tb/asram_seq_ctrl_tb.sv
`timescale 1ns/1ps
module asram_seq_ctrl_tb;
   localparam int AW      = 20;
   localparam int DW      = 16;
   localparam int PWR_CYC = 25000;  // 200000 ns / 8 ns
   localparam int RD_CYC  = 7;      // ceil(55/8)
   localparam int WPL_CYC = 5;      // ceil(40/8)
   localparam int SD_CYC  = 4;      // ceil(25/8)
   localparam int HZ_REL  = 2;      // model keeps driving 2 cycles after OE rises

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0, req_wr = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_be = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          ack;
   logic [DW-1:0] rdata;
   logic [AW-1:0] sram_addr;
   logic          sram_sel_n, sram_sel, sram_we_n, sram_oe_n, sram_dq_oe;
   logic [1:0]    sram_lane_n;
   logic [DW-1:0] sram_dq_out, sram_dq_in;

   always #4 clk = ~clk;

   asram_seq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
      .req_be(req_be), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
      .sram_addr(sram_addr), .sram_sel_n(sram_sel_n), .sram_sel(sram_sel),
      .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_lane_n(sram_lane_n),
      .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe)
   );

   int n_chk = 0, n_err = 0;
   task automatic chk(input bit ok, input string req_tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] init_word(input int i);
      return 16'(i * 16'h0101) ^ 16'h5A5A;
   endfunction

   // ---------------- memory model ----------------
   logic [15:0] mem [256];
   logic [15:0] ref_mem [256];
   initial for (int i = 0; i < 256; i++) begin
      mem[i]     = init_word(i);
      ref_mem[i] = init_word(i);
   end

   wire sel_on = !sram_sel_n && sram_sel;
   wire dev_rd = sel_on && !sram_oe_n && sram_we_n && (sram_lane_n != 2'b11);
   wire strobe = sel_on && !sram_we_n && (sram_lane_n != 2'b11);
   int  rd_cnt = 0, rel = 0, wl = 0, sd = 0, pc = 0, sel_cnt = 0;
   int  cyc = 0, first_sel = -1;
   bit  st_prev = 0, clash = 0, oe_bad = 0, addr_bad = 0;
   logic [15:0] d_prev = '0;
   logic [1:0]  ln_prev = 2'b11;
   logic [7:0]  a_prev = '0;
   logic [AW-1:0] a_sel = '0;

   assign sram_dq_in = (dev_rd && rd_cnt >= RD_CYC) ? mem[sram_addr[7:0]] : 16'hBAD0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         rd_cnt <= dev_rd ? rd_cnt + 1 : 0;
         if (sram_dq_oe && (dev_rd || rel != 0)) clash <= 1;
         rel <= dev_rd ? HZ_REL : ((rel != 0) ? rel - 1 : 0);
         if (strobe) begin
            if (!sram_oe_n) oe_bad <= 1;
            wl <= st_prev ? wl + 1 : 1;
            sd <= (st_prev && sram_dq_oe && sram_dq_out == d_prev) ? sd + 1 : (sram_dq_oe ? 1 : 0);
         end
         if (st_prev && !strobe) begin
            if (!ln_prev[0]) mem[a_prev][7:0]  <= d_prev[7:0];
            if (!ln_prev[1]) mem[a_prev][15:8] <= d_prev[15:8];
            chk(wl >= WPL_CYC, "R4", "write strobe cycles", 32'(wl), 32'(WPL_CYC));
            chk(sd >= SD_CYC, "R4", "data stable before strobe end", 32'(sd), 32'(SD_CYC));
            chk(sram_dq_oe == 1'b1, "R6", "drive in strobe-end cycle", 32'(sram_dq_oe), 32'd1);
            pc <= 1;
         end
         if (pc == 1) begin
            chk(sram_dq_oe == 1'b0, "R6", "drive one cycle after strobe end", 32'(sram_dq_oe), 32'd0);
            pc <= 0;
         end
         st_prev <= strobe;
         d_prev  <= sram_dq_out;
         ln_prev <= sram_lane_n;
         a_prev  <= sram_addr[7:0];
         if (sel_on) begin
            if (sel_cnt > 0 && sram_addr != a_sel) addr_bad <= 1;
            a_sel   <= sram_addr;
            sel_cnt <= sel_cnt + 1;
            if (first_sel < 0) first_sel <= cyc;
         end else if (sel_cnt != 0) begin
            chk(sel_cnt >= RD_CYC, "R11", "selected cycles per access", 32'(sel_cnt), 32'(RD_CYC));
            sel_cnt <= 0;
         end
      end
   end

   // ---------------- scoreboard ----------------
   logic [16:0] sb[$];
   string       tagq[$];
   bit          ack_prev = 0;
   bit          quiet = 0, touched = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (quiet && (sel_on || !sram_we_n || !sram_oe_n || sram_lane_n != 2'b11 || sram_dq_oe))
            touched <= 1;
         if (ack) begin
            chk(!ack_prev, "R8", "ack longer than one cycle", 32'(ack_prev), 32'd0);
            if (sb.size() == 0) chk(0, "R8", "ack without request", 32'd1, 32'd0);
            else begin
               logic [16:0] it;
               string       tg;
               it = sb.pop_front();
               tg = tagq.pop_front();
               if (it[16]) chk(rdata == it[15:0], tg, "read data", 32'(rdata), 32'(it[15:0]));
            end
         end
         ack_prev <= ack;
      end
   end

   task automatic access(input bit wr, input logic [7:0] a, input logic [1:0] be,
                         input logic [15:0] d, input string tg);
      logic [15:0] e;
      e = '0;
      for (int l = 0; l < 2; l++) begin
         if (be[l]) begin
            if (wr) ref_mem[a][l*8 +: 8] = d[l*8 +: 8];
            else    e[l*8 +: 8] = ref_mem[a][l*8 +: 8];
         end
      end
      sb.push_back({(!wr && be != 2'b00), e});
      tagq.push_back(tg);
      @(negedge clk);
      req = 1'b1; req_wr = wr; req_addr = {12'h000, a}; req_be = be; req_wdata = d;
      do @(negedge clk); while (!ack);
      req = 1'b0;
   endtask

   bit done = 0;
   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual running expected done");
         summary();
      end
   end

   initial begin
      logic [AW-1:0] a_before;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk({sram_sel_n, sram_sel, sram_we_n, sram_oe_n, sram_lane_n, sram_dq_oe, ack} == 8'b1011_1100,
          "R1", "pins in reset",
          32'({sram_sel_n, sram_sel, sram_we_n, sram_oe_n, sram_lane_n, sram_dq_oe, ack}), 32'hBC);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sram_sel_n && !sram_sel && sram_dq_oe == 0 && ack == 0, "R1", "pins after reset",
          32'({sram_sel_n, sram_sel}), 32'h2);
      // request before power-up completes must wait (R1, R2)
      access(0, 8'h10, 2'b11, 16'h0, "R2");
      chk(first_sel >= PWR_CYC, "R1", "first select cycle", 32'(first_sel), 32'(PWR_CYC));
      // full word write then read (R2, R4)
      access(1, 8'h10, 2'b11, 16'hA55A, "R4");
      access(0, 8'h10, 2'b11, 16'h0, "R2");
      // lane writes (R10)
      access(1, 8'h11, 2'b01, 16'h1234, "R10");
      access(0, 8'h11, 2'b11, 16'h0, "R10");
      access(1, 8'h11, 2'b10, 16'hABCD, "R10");
      access(0, 8'h11, 2'b11, 16'h0, "R10");
      // lane reads zero the other lane (R3)
      access(0, 8'h11, 2'b01, 16'h0, "R3");
      access(0, 8'h11, 2'b10, 16'h0, "R3");
      // read immediately followed by write: turn-around (R5)
      access(0, 8'h13, 2'b11, 16'h0, "R2");
      access(1, 8'h13, 2'b11, 16'h0F0F, "R5");
      access(0, 8'h13, 2'b11, 16'h0, "R5");
      // no lanes enabled (R9)
      @(negedge clk);
      a_before = sram_addr;
      touched = 0; quiet = 1;
      access(1, 8'h12, 2'b00, 16'hFFFF, "R9");
      quiet = 0;
      chk(!touched, "R9", "pins toggled", 32'(touched), 32'd0);
      chk(sram_addr == a_before, "R9", "address moved", 32'(sram_addr), 32'(a_before));
      access(0, 8'h12, 2'b11, 16'h0, "R9");
      // address sweep (R2, R4, R7)
      for (int i = 0; i < 8; i++)
         access(1, 8'(8'h20 + i), 2'b11, 16'(i * 16'h1111) ^ 16'h0F0F, "R4");
      for (int i = 0; i < 8; i++)
         access(0, 8'(8'h20 + i), 2'b11, 16'h0, "R7");
      repeat (4) @(negedge clk);
      chk(!clash, "R5", "bus contention seen", 32'(clash), 32'd0);
      chk(!oe_bad, "R4", "OE low during strobe", 32'(oe_bad), 32'd0);
      chk(!addr_bad, "R7", "address moved while selected", 32'(addr_bad), 32'd0);
      chk(sb.size() == 0, "R8", "requests without ack", 32'(sb.size()), 32'd0);
      done = 1;
      summary();
   end
endmodule